// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM command bus and takes the memory from reset to an operational state. While reset is held, and for a fixed stable period after it is released, the block keeps the clock-enable and data-mask pins high and places only no-operation commands on the bus. The length of that period is given in microseconds and turned into clock cycles with a clock-frequency parameter. The sequencer then closes every bank with one precharge. It issues a parameterized number of auto-refresh commands, with at least two always sent. It writes the mode register from a parameter word.

Every command is followed by a parameterized run of no-operation cycles so that the memory's recovery times are met. A parameter chooses whether the refresh burst or the mode-register write comes first. When the last recovery window closes, the block raises `init_done`. From then on it keeps the bus idle, so that the normal-operation controller can take over the command pins. `init_done` stays high until the next reset.

The state machine has eight states: `S_HOLD` (stable wait), `S_PRECHARGE`, `S_PRE_GAP`, `S_REFRESH`, `S_REF_GAP`, `S_MODE`, `S_MODE_GAP` and `S_READY`. Its transitions are as follows:

- Reset: reset leads to `S_HOLD`.
- Leaving the wait states: `S_HOLD`, `S_PRE_GAP`, `S_REF_GAP` and `S_MODE_GAP` each advance when their cycle timer has expired.
- Command states: `S_PRECHARGE` always moves to `S_PRE_GAP`. `S_REFRESH` always moves to `S_REF_GAP`. `S_MODE` always moves to `S_MODE_GAP`.
- After `S_PRE_GAP`: the machine goes to `S_REFRESH` when the mode write is configured to come last, and to `S_MODE` when it is configured to come first.
- After `S_REF_GAP`: the machine returns to `S_REFRESH` while refreshes remain. Once they are all sent, it goes to `S_MODE` (mode write last) or to `S_READY` (mode write first).
- After `S_MODE_GAP`: the machine goes to `S_READY` (mode write last) or to `S_REFRESH` (mode write first).
- `S_READY` holds until reset.

Top module: `sdram_init_seq`

## Requirements
- R1: `cke` and `dqm` are 1 during reset and during every cycle after it.
- R2: A no-operation command is on the bus during reset and for exactly CLK_MHZ*HOLD_US cycles after reset is released. The no-operation encoding on {cs_n,ras_n,cas_n,we_n} is 0111. The first other command appears in cycle CLK_MHZ*HOLD_US, counting the first cycle after release as cycle 0.
- R3: The first command after the wait is a precharge. It is encoded as {cs_n,ras_n,cas_n,we_n}=0010 and drives addr[10]=1 so that it targets all banks.
- R4: Auto-refresh is encoded as 0001. It is issued max(REFRESH_COUNT,2) times, so a setting below 2 still gives 2.
- R5: The mode-register write is encoded as 0000. On that cycle, addr[6:0] and addr[9] carry the same bits of MODE_WORD. Those bits are burst length in [2:0], burst type in [3], CAS latency in [6:4] and write burst mode in [9].
- R6: During the mode-register write, addr[8:7], addr[11:10] and ba[1:0] are 0 whatever MODE_WORD holds.
- R7: The precharge is followed by exactly GAP_PRE no-operation cycles. Each auto-refresh is followed by exactly GAP_REF no-operation cycles. The mode write is followed by exactly GAP_MODE no-operation cycles. Each gap is raised to 1 if it is set lower.
- R8: With MODE_FIRST=0 all refreshes come before the mode write. With MODE_FIRST=1 the mode write comes before all refreshes. No other commands are issued.
- R9: `init_done` is 0 during reset. It rises in the cycle after the final gap ends. It then stays 1, with the bus idle (no-operation), until reset is asserted again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory, held high |
| dqm | output | 1 | Data mask to the memory, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 12 | Address bus; carries all-bank flag and mode word |
| init_done | output | 1 | Memory initialized; bus may be handed over |

## Verification
Two instances run side by side with different configurations, so the two command orders can be told apart.
- The first instance uses the refresh-first order, three refreshes, unequal precharge and refresh gaps, and a clean mode word. The unequal gaps show whether each recovery window is timed from its own parameter.
- The second instance uses the mode-first order, a refresh count of 1 that must be raised to 2, and a mode word with every reserved bit set. These settings expose a missing clamp and any reserved bit that reaches the address pins.

Every cycle's command is compared with a schedule the bench builds itself, so that a command that comes early, late, extra or in the wrong order shows up as a position error. A reset after `init_done` confirms that the sequence starts again from the stable wait.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        S_HOLD,
        S_PRECHARGE,
        S_PRE_GAP,
        S_REFRESH,
        S_REF_GAP,
        S_MODE,
        S_MODE_GAP,
        S_READY
    } init_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRE_ALL,
        CMD_REFRESH,
        CMD_MODE
    } init_cmd_e;

    // Mode-word bits allowed onto the address pins: [6:0] and [9]
    localparam logic [11:0] MODE_KEEP_MASK = 12'h27F;

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int             CW        = 16,
    parameter logic [CW-1:0]  RESET_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RESET_VAL;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdram_cmd_encode.sv
module sdram_cmd_encode
    import sdram_init_pkg::*;
#(
    parameter logic [11:0] MODE_WORD = 12'h033
) (
    input  init_cmd_e   cmd,
    output logic        cke,
    output logic        dqm,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [11:0] addr
);

    localparam logic [11:0] MODE_LEGAL = MODE_WORD & MODE_KEEP_MASK;

    assign cke = 1'b1;
    assign dqm = 1'b1;
    assign ba  = 2'b00;

    always_comb begin
        cs_n  = 1'b0;
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        addr  = '0;
        unique case (cmd)
            CMD_NOP: begin
            end
            CMD_PRE_ALL: begin
                ras_n = 1'b0;
                we_n  = 1'b0;
                addr  = 12'h400;
            end
            CMD_REFRESH: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MODE: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr  = MODE_LEGAL;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int          CLK_MHZ       = 100,
    parameter int          HOLD_US       = 200,
    parameter int          REFRESH_COUNT = 8,
    parameter int          GAP_PRE       = 3,
    parameter int          GAP_REF       = 7,
    parameter int          GAP_MODE      = 2,
    parameter bit          MODE_FIRST    = 1'b0,
    parameter logic [11:0] MODE_WORD     = 12'h233
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        cke,
    output logic        dqm,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [11:0] addr,
    output logic        init_done
);

    localparam int HOLD_CYC = (CLK_MHZ * HOLD_US < 1) ? 1 : CLK_MHZ * HOLD_US;
    localparam int REFS     = (REFRESH_COUNT < 2) ? 2 : REFRESH_COUNT;
    localparam int GP       = (GAP_PRE  < 1) ? 1 : GAP_PRE;
    localparam int GR       = (GAP_REF  < 1) ? 1 : GAP_REF;
    localparam int GM       = (GAP_MODE < 1) ? 1 : GAP_MODE;
    localparam int CW       = $clog2(HOLD_CYC + GP + GR + GM + 1);
    localparam int RW       = $clog2(REFS + 1);

    localparam logic [CW-1:0] LD_HOLD = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] LD_PRE  = CW'(GP - 1);
    localparam logic [CW-1:0] LD_REF  = CW'(GR - 1);
    localparam logic [CW-1:0] LD_MODE = CW'(GM - 1);
    localparam logic [RW-1:0] REFS_W  = RW'(REFS);

    init_state_e   st_q, st_d;
    logic [RW-1:0] refs_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          refs_all;
    init_cmd_e     cmd;

    sdram_init_timer #(
        .CW        (CW),
        .RESET_VAL (LD_HOLD)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    assign refs_all = (refs_q == REFS_W);

    // State register and refresh tally
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_HOLD;
            refs_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == S_REFRESH) begin
                refs_q <= refs_q + 1'b1;
            end
        end
    end

    // Next-state and timer loading
    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q)
            S_HOLD: begin
                if (tmr_done) st_d = S_PRECHARGE;
            end
            S_PRECHARGE: begin
                st_d     = S_PRE_GAP;
                tmr_load = 1'b1;
                tmr_val  = LD_PRE;
            end
            S_PRE_GAP: begin
                if (tmr_done) st_d = MODE_FIRST ? S_MODE : S_REFRESH;
            end
            S_REFRESH: begin
                st_d     = S_REF_GAP;
                tmr_load = 1'b1;
                tmr_val  = LD_REF;
            end
            S_REF_GAP: begin
                if (tmr_done) begin
                    if (!refs_all)      st_d = S_REFRESH;
                    else if (MODE_FIRST) st_d = S_READY;
                    else                 st_d = S_MODE;
                end
            end
            S_MODE: begin
                st_d     = S_MODE_GAP;
                tmr_load = 1'b1;
                tmr_val  = LD_MODE;
            end
            S_MODE_GAP: begin
                if (tmr_done) st_d = MODE_FIRST ? S_REFRESH : S_READY;
            end
            S_READY: begin
                st_d = S_READY;
            end
            default: st_d = S_HOLD;
        endcase
    end

    // Outputs from state
    always_comb begin
        cmd       = CMD_NOP;
        init_done = 1'b0;
        unique case (st_q)
            S_PRECHARGE: cmd = CMD_PRE_ALL;
            S_REFRESH:   cmd = CMD_REFRESH;
            S_MODE:      cmd = CMD_MODE;
            S_READY:     init_done = 1'b1;
            S_HOLD, S_PRE_GAP, S_REF_GAP, S_MODE_GAP: cmd = CMD_NOP;
            default:     cmd = CMD_NOP;
        endcase
    end

    sdram_cmd_encode #(
        .MODE_WORD (MODE_WORD)
    ) u_enc (
        .cmd   (cmd),
        .cke   (cke),
        .dqm   (dqm),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .ba    (ba),
        .addr  (addr)
    );

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cke,
    input logic        dqm,
    input logic        cs_n,
    input logic        ras_n,
    input logic        cas_n,
    input logic        we_n,
    input logic [1:0]  ba,
    input logic [11:0] addr,
    input logic        init_done
);

    logic bus_idle, is_pre, is_mode;
    assign bus_idle = !cs_n && ras_n && cas_n && we_n;
    assign is_pre   = !cs_n && !ras_n && cas_n && !we_n;
    assign is_mode  = !cs_n && !ras_n && !cas_n && !we_n;

    AST_PINS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) cke && dqm); // R1
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n) is_pre |-> addr[10]); // R3
    AST_MODE_RESERVED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |-> (addr[8:7] == 2'b00 && addr[11:10] == 2'b00 && ba == 2'b00)); // R6
    AST_GAP_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n) !bus_idle |=> bus_idle); // R7
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n) init_done |=> init_done); // R9
    AST_READY_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n) init_done |-> bus_idle); // R9

endmodule

bind sdram_init_seq sdram_init_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .dqm       (dqm),
    .cs_n      (cs_n),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .ba        (ba),
    .addr      (addr),
    .init_done (init_done)
);

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
module tb_sdram_init_seq;

    localparam int MHZ  = 50;
    localparam int HOLD = MHZ * 200;

    localparam int K_NOP = 0, K_PRE = 1, K_REF = 2, K_MODE = 3, K_BAD = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [1:0] cke, dqm, cs_n, ras_n, cas_n, we_n, rdy;
    logic [1:0]  ba   [2];
    logic [11:0] addr [2];

    sdram_init_seq #(
        .CLK_MHZ(MHZ), .HOLD_US(200), .REFRESH_COUNT(3), .GAP_PRE(3), .GAP_REF(7),
        .GAP_MODE(2), .MODE_FIRST(1'b0), .MODE_WORD(12'h233)
    ) dut (
        .clk(clk), .rst_n(rst_n), .cke(cke[0]), .dqm(dqm[0]), .cs_n(cs_n[0]),
        .ras_n(ras_n[0]), .cas_n(cas_n[0]), .we_n(we_n[0]), .ba(ba[0]),
        .addr(addr[0]), .init_done(rdy[0])
    );

    sdram_init_seq #(
        .CLK_MHZ(MHZ), .HOLD_US(200), .REFRESH_COUNT(1), .GAP_PRE(2), .GAP_REF(4),
        .GAP_MODE(2), .MODE_FIRST(1'b1), .MODE_WORD(12'hFB7)
    ) dut_alt (
        .clk(clk), .rst_n(rst_n), .cke(cke[1]), .dqm(dqm[1]), .cs_n(cs_n[1]),
        .ras_n(ras_n[1]), .cas_n(cas_n[1]), .we_n(we_n[1]), .ba(ba[1]),
        .addr(addr[1]), .init_done(rdy[1])
    );

    int n_chk = 0;
    int n_bad = 0;

    int exp_kind [2][8];
    int exp_at   [2][8];
    int exp_n    [2];
    int rdy_at   [2];
    int next_ev  [2];
    logic [11:0] exp_mode [2];
    bit pins_ok [2];
    bit rdy_ok  [2];
    bit extra_ok[2];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
        end
    endtask

    function automatic int kind_of(input int d);
        case ({cs_n[d], ras_n[d], cas_n[d], we_n[d]})
            4'b0111: return K_NOP;
            4'b0010: return K_PRE;
            4'b0001: return K_REF;
            4'b0000: return K_MODE;
            default: return K_BAD;
        endcase
    endfunction

    task automatic add_ev(input int d, input int k, input int t);
        exp_kind[d][exp_n[d]] = k;
        exp_at[d][exp_n[d]]   = t;
        exp_n[d]++;
    endtask

    task automatic plan(input int d, input bit mf, input int refs, input int gp,
                        input int gr, input int gm, input logic [11:0] mode);
        int t = HOLD;
        exp_n[d] = 0;
        exp_mode[d] = mode;
        add_ev(d, K_PRE, t);
        t += 1 + gp;
        if (mf) begin
            add_ev(d, K_MODE, t);
            t += 1 + gm;
        end
        for (int r = 0; r < refs; r++) begin
            add_ev(d, K_REF, t);
            t += 1 + gr;
        end
        if (!mf) begin
            add_ev(d, K_MODE, t);
            t += 1 + gm;
        end
        rdy_at[d] = t;
    endtask

    task automatic observe(input int d, input int cyc);
        int k = kind_of(d);
        if (!(cke[d] && dqm[d])) pins_ok[d] = 1'b0;
        if (k != K_NOP) begin
            if (next_ev[d] >= exp_n[d]) begin
                extra_ok[d] = 1'b0;
            end else begin
                int i = next_ev[d];
                check(k == exp_kind[d][i], (i == 0) ? "R3" : "R8", "command kind", k, exp_kind[d][i]);
                check(cyc == exp_at[d][i], (i == 0) ? "R2" : "R7", "command cycle", cyc, exp_at[d][i]);
                if (k == K_PRE) check(addr[d][10] == 1'b1, "R3", "precharge addr[10]", int'(addr[d][10]), 1);
                if (k == K_MODE) begin
                    check((addr[d] & 12'h27F) == (exp_mode[d] & 12'h27F), "R5", "mode fields",
                          int'(addr[d]), int'(exp_mode[d] & 12'h27F));
                    check(addr[d][8:7] == 2'b00 && addr[d][11:10] == 2'b00 && ba[d] == 2'b00,
                          "R6", "reserved mode bits", int'({ba[d], addr[d]}), int'(exp_mode[d] & 12'h27F));
                end
                next_ev[d]++;
            end
        end
        if (cyc < rdy_at[d] && rdy[d]) rdy_ok[d] = 1'b0;
        if (cyc == rdy_at[d]) check(rdy[d] == 1'b1, "R9", "init_done rise", int'(rdy[d]), 1);
        if (cyc > rdy_at[d] && (!rdy[d] || k != K_NOP)) rdy_ok[d] = 1'b0;
    endtask

    task automatic test_reset_state();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            check(cke[d] && dqm[d], "R1", "cke/dqm in reset", int'({cke[d], dqm[d]}), 3);
            check(kind_of(d) == K_NOP, "R2", "bus idle in reset", kind_of(d), K_NOP);
            check(rdy[d] == 1'b0, "R9", "init_done in reset", int'(rdy[d]), 0);
        end
    endtask

    task automatic test_power_up();
        int last;
        plan(0, 1'b0, 3, 3, 7, 2, 12'h233);
        plan(1, 1'b1, 2, 2, 4, 2, 12'hFB7);
        for (int d = 0; d < 2; d++) begin
            next_ev[d] = 0; pins_ok[d] = 1'b1; rdy_ok[d] = 1'b1; extra_ok[d] = 1'b1;
        end
        last = ((rdy_at[0] > rdy_at[1]) ? rdy_at[0] : rdy_at[1]) + 40;
        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc <= last; cyc++) begin
            #1;
            for (int d = 0; d < 2; d++) observe(d, cyc);
            @(negedge clk);
        end
        for (int d = 0; d < 2; d++) begin
            check(next_ev[d] == exp_n[d], "R4", "commands issued", next_ev[d], exp_n[d]);
            check(extra_ok[d], "R8", "no extra commands", int'(extra_ok[d]), 1);
            check(pins_ok[d], "R1", "cke/dqm held high", int'(pins_ok[d]), 1);
            check(rdy_ok[d], "R9", "init_done timing and idle bus", int'(rdy_ok[d]), 1);
        end
    endtask

    task automatic test_rereset();
        bit quiet = 1'b1;
        rst_n = 1'b0;
        #2;
        for (int d = 0; d < 2; d++)
            check(rdy[d] == 1'b0 && kind_of(d) == K_NOP, "R9", "reset clears init_done",
                  int'(rdy[d]), 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 200; cyc++) begin
            #1;
            for (int d = 0; d < 2; d++)
                if (kind_of(d) != K_NOP || rdy[d]) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R2", "hold restarts after reset", int'(quiet), 1);
    endtask

    initial begin
        test_reset_state();
        test_power_up();
        test_rereset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule